// File: doc/BRIEF.md
# Byte-Coded Operand Resolving Execute Unit

This block executes one arithmetic, logic or shift instruction whose operands arrive as single bytes. Each operand byte works as an addressing mode. A small value is a literal. A byte from a short register window selects the accumulator or one of the processor registers that are presented on the input ports. The result is written to a 16-bit accumulator that the unit holds. A 4-bit status code reports success, a bad operator, a bad operand or an arithmetic fault. A family of wide opcodes ignores register addressing and joins both operand bytes into a 16-bit immediate that acts on the accumulator.

A sequencer pulses `start_i` for one cycle with the opcode and both operand bytes. The sequencer then waits for `done_o`. Execution takes one, two or three cycles, depending on the operation. While the unit is working, it reports busy and ignores further starts. Fetch, decode of other instruction classes and sequencing belong outside this block.

Top module: `bytecode_alu`

## Requirements
- R1: After reset the accumulator is 0, the status is 0, and `busy_o` and `done_o` are low.
- R2: An operand byte from 0x00 to 0x9F is a literal, zero-extended to 16 bits.
- R3: Operand bytes 0xD0..0xD8 select, in this order: accumulator, error input (zero-extended), I/O-B input, program counter input, stack pointer input, full I/O-A input, I/O-B input, I/O-A bits 15:8 and I/O-A bits 7:0.
- R4: For opcodes 0xB0..0xB7 a second operand byte of 0x00 gives the result accumulator OP operand1. Any other second byte gives operand1 OP operand2.
- R5: The opcodes are 0xB0 add, 0xB1 subtract, 0xB2 multiply, 0xB3 divide, 0xB4 modulo, 0xB5 AND, 0xB6 OR and 0xB7 XOR, all unsigned. Results keep the low 16 bits, and divide floors the quotient.
- R6: Opcode 0xBA shifts operand1 left by operand2, and 0xBB shifts it right (logical). Both operands are always resolved. A shift amount of 16 or more gives 0.
- R7: Opcodes 0xE0..0xE7 (add, subtract, multiply, divide, modulo, AND, OR, XOR) combine the accumulator with the immediate {operand1 byte, operand2 byte}, with operand1 as the high byte. Opcode 0xE8 loads that immediate into the accumulator.
- R8: The result, `done_o` and status 4 appear after N rising edges, counting the accepting edge. N is 3 for multiply and divide, 2 for add, subtract and modulo, and 1 for the others. Between those edges `busy_o` is high, the status is 2 and `done_o` is low. `done_o` lasts one cycle.
- R9: For a non-wide opcode, any operand byte that is needed and lies outside R2 and R3 gives status 0xB one edge after start. The accumulator is left unchanged.
- R10: Any opcode outside the sets above gives status 0xA one edge after start. The accumulator is left unchanged.
- R11: Divide or modulo by zero gives status 0xD after the operation's normal latency. The accumulator is left unchanged.
- R12: A start asserted while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin executing the presented instruction |
| opcode_i | input | 8 | Operator byte |
| opnd1_i | input | 8 | First operand byte |
| opnd2_i | input | 8 | Second operand byte |
| err_i | input | 4 | Error register value |
| pc_i | input | 8 | Program counter value |
| sp_i | input | 4 | Stack pointer value |
| ioa_i | input | 16 | I/O-A register value |
| iob_i | input | 8 | I/O-B register value |
| acc_o | output | 16 | Accumulator |
| status_o | output | 4 | Status code |
| busy_o | output | 1 | Multi-cycle operation in progress |
| done_o | output | 1 | One-cycle pulse when a result or error is posted |

## Verification
Decode errors are due one edge after the accepting edge. Logic ops, shifts and wide load are also due one edge later. Add, subtract and modulo are due two edges later, and multiply and divide three, division faults included. For every instruction the bench computes that count from the opcode and the operand validity. At each falling edge in between, it checks busy high, status 2 and done low. At the falling edge after the final edge, it checks the accumulator, the status and the done pulse. Before the next start it checks that done has dropped.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int CW = 8;

    typedef enum logic [3:0] {
        ST_READY    = 4'h0,
        ST_BUSY     = 4'h2,
        ST_DONE     = 4'h4,
        ST_BAD_OP   = 4'hA,
        ST_BAD_OPND = 4'hB,
        ST_ARITH    = 4'hD
    } status_e;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_MUL, K_DIV, K_MOD,
        K_AND, K_OR, K_XOR, K_SHL, K_SHR, K_LOAD
    } kind_e;

    typedef struct packed {
        logic       legal;
        logic       wide;
        logic       shift;
        kind_e      kind;
        logic [1:0] cost;
    } dec_t;

    function automatic logic [1:0] kind_cost(input kind_e k);
        case (k)
            K_MUL, K_DIV:        kind_cost = 2'd3;
            K_ADD, K_SUB, K_MOD: kind_cost = 2'd2;
            default:             kind_cost = 2'd1;
        endcase
    endfunction

    function automatic dec_t decode_op(input logic [CW-1:0] op);
        dec_t d;
        d.legal = 1'b1;
        d.wide  = 1'b0;
        d.shift = 1'b0;
        d.kind  = K_ADD;
        if (op >= 8'hB0 && op <= 8'hB7) begin
            d.kind = kind_e'(op[3:0]);
        end else if (op == 8'hBA) begin
            d.kind  = K_SHL;
            d.shift = 1'b1;
        end else if (op == 8'hBB) begin
            d.kind  = K_SHR;
            d.shift = 1'b1;
        end else if (op >= 8'hE0 && op <= 8'hE8) begin
            d.wide = 1'b1;
            d.kind = (op == 8'hE8) ? K_LOAD : kind_e'(op[3:0]);
        end else begin
            d.legal = 1'b0;
        end
        d.cost = kind_cost(d.kind);
        return d;
    endfunction

endpackage

// File: rtl/opnd_resolve.sv
module opnd_resolve #(
    parameter int DW    = 16,
    parameter int ERR_W = 4,
    parameter int PC_W  = 8,
    parameter int SP_W  = 4,
    parameter int IOB_W = 8
) (
    input  logic [alu_pkg::CW-1:0] code_i,
    input  logic [DW-1:0]          acc_i,
    input  logic [ERR_W-1:0]       err_i,
    input  logic [PC_W-1:0]        pc_i,
    input  logic [SP_W-1:0]        sp_i,
    input  logic [DW-1:0]          ioa_i,
    input  logic [IOB_W-1:0]       iob_i,
    output logic [DW-1:0]          value_o,
    output logic                   valid_o
);
    localparam int CW = alu_pkg::CW;

    always_comb begin
        value_o = '0;
        valid_o = 1'b1;
        if (code_i <= 8'h9F) begin
            value_o = DW'(code_i);
        end else begin
            case (code_i)
                8'hD0:   value_o = acc_i;
                8'hD1:   value_o = DW'(err_i);
                8'hD2:   value_o = DW'(iob_i);
                8'hD3:   value_o = DW'(pc_i);
                8'hD4:   value_o = DW'(sp_i);
                8'hD5:   value_o = ioa_i;
                8'hD6:   value_o = DW'(iob_i);
                8'hD7:   value_o = DW'(ioa_i[DW-1 -: CW]);
                8'hD8:   value_o = DW'(ioa_i[CW-1:0]);
                default: valid_o = 1'b0;
            endcase
        end
        // R9: only the reserved byte ranges may be rejected
        p_reserved_only_r9: assert (valid_o || (code_i > 8'h9F && (code_i < 8'hD0 || code_i > 8'hD8)))
            else $error("operand rejected inside a legal range");
    end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath #(
    parameter int DW = 16
) (
    input  alu_pkg::kind_e kind_i,
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    output logic [DW-1:0]  res_o,
    output logic           fault_o
);
    import alu_pkg::*;

    localparam int          SHW    = $clog2(DW);
    localparam logic [DW-1:0] SH_LIM = DW[DW-1:0];

    logic          div_zero;
    logic [DW-1:0] divisor;
    logic          sh_over;

    always_comb begin
        div_zero = (b_i == '0);
        divisor  = div_zero ? {{(DW-1){1'b0}}, 1'b1} : b_i;
        sh_over  = (b_i >= SH_LIM);
        fault_o  = 1'b0;
        res_o    = '0;
        case (kind_i)
            K_ADD:  res_o = a_i + b_i;
            K_SUB:  res_o = a_i - b_i;
            K_MUL:  res_o = a_i * b_i;
            K_DIV: begin
                res_o   = a_i / divisor;
                fault_o = div_zero;
            end
            K_MOD: begin
                res_o   = a_i % divisor;
                fault_o = div_zero;
            end
            K_AND:  res_o = a_i & b_i;
            K_OR:   res_o = a_i | b_i;
            K_XOR:  res_o = a_i ^ b_i;
            K_SHL:  res_o = sh_over ? '0 : (a_i << b_i[SHW-1:0]);
            K_SHR:  res_o = sh_over ? '0 : (a_i >> b_i[SHW-1:0]);
            default: res_o = b_i;
        endcase
        // R5: a floored unsigned quotient never exceeds its dividend
        p_quot_bounded_r5: assert (kind_i != K_DIV || fault_o || res_o <= a_i)
            else $error("quotient larger than dividend");
        // R11: the fault flag only comes from division kinds
        p_fault_kind_r11: assert (!fault_o || kind_i == K_DIV || kind_i == K_MOD)
            else $error("fault from non-division op");
    end

endmodule

// File: rtl/bytecode_alu.sv
module bytecode_alu #(
    parameter int DW    = 16,
    parameter int ERR_W = 4,
    parameter int PC_W  = 8,
    parameter int SP_W  = 4,
    parameter int IOB_W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [7:0]   opcode_i,
    input  logic [7:0]   opnd1_i,
    input  logic [7:0]   opnd2_i,
    input  logic [3:0]   err_i,
    input  logic [7:0]   pc_i,
    input  logic [3:0]   sp_i,
    input  logic [15:0]  ioa_i,
    input  logic [7:0]   iob_i,
    output logic [15:0]  acc_o,
    output logic [3:0]   status_o,
    output logic         busy_o,
    output logic         done_o
);
    import alu_pkg::*;

    localparam int NOPND = 2;

    typedef struct packed {
        logic [DW-1:0] acc;
        status_e       status;
        logic          busy;
        logic          done;
        logic [1:0]    cnt;
        logic [DW-1:0] pend_res;
        logic          pend_fault;
    } state_t;

    state_t st_d, st_q;

    dec_t          dec;
    logic [CW-1:0] codes [NOPND];
    logic [DW-1:0] vals  [NOPND];
    logic          oks   [NOPND];
    logic          one_form;
    logic          opnds_ok;
    logic [DW-1:0] a_sel, b_sel;
    logic [DW-1:0] res;
    logic          fault;

    assign codes[0] = opnd1_i;
    assign codes[1] = opnd2_i;

    generate
        for (genvar g = 0; g < NOPND; g++) begin : g_opnd
            opnd_resolve #(
                .DW(DW), .ERR_W(ERR_W), .PC_W(PC_W), .SP_W(SP_W), .IOB_W(IOB_W)
            ) res_i (
                .code_i (codes[g]),
                .acc_i  (st_q.acc),
                .err_i  (err_i),
                .pc_i   (pc_i),
                .sp_i   (sp_i),
                .ioa_i  (ioa_i),
                .iob_i  (iob_i),
                .value_o(vals[g]),
                .valid_o(oks[g])
            );
        end
    endgenerate

    always_comb begin
        dec      = decode_op(opcode_i);
        one_form = !dec.wide && !dec.shift && (opnd2_i == '0);
        opnds_ok = dec.wide || (oks[0] && (one_form || oks[1]));
        if (dec.wide) begin
            a_sel = st_q.acc;
            b_sel = DW'({opnd1_i, opnd2_i});
        end else if (one_form) begin
            a_sel = st_q.acc;
            b_sel = vals[0];
        end else begin
            a_sel = vals[0];
            b_sel = vals[1];
        end
    end

    alu_datapath #(.DW(DW)) dp_i (
        .kind_i (dec.kind),
        .a_i    (a_sel),
        .b_i    (b_sel),
        .res_o  (res),
        .fault_o(fault)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == 2'd1) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
                st_d.done = 1'b1;
                if (st_q.pend_fault) begin
                    st_d.status = ST_ARITH;
                end else begin
                    st_d.status = ST_DONE;
                    st_d.acc    = st_q.pend_res;
                end
            end else begin
                st_d.cnt = st_q.cnt - 2'd1;
            end
        end else if (start_i) begin
            if (!dec.legal) begin
                st_d.done   = 1'b1;
                st_d.status = ST_BAD_OP;
            end else if (!opnds_ok) begin
                st_d.done   = 1'b1;
                st_d.status = ST_BAD_OPND;
            end else if (dec.cost == 2'd1) begin
                st_d.done   = 1'b1;
                st_d.status = fault ? ST_ARITH : ST_DONE;
                if (!fault) st_d.acc = res;
            end else begin
                st_d.busy       = 1'b1;
                st_d.cnt        = dec.cost - 2'd1;
                st_d.status     = ST_BUSY;
                st_d.pend_res   = res;
                st_d.pend_fault = fault;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{acc: '0, status: ST_READY, busy: 1'b0, done: 1'b0,
                      cnt: '0, pend_res: '0, pend_fault: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o    = st_q.acc;
    assign status_o = st_q.status;
    assign busy_o   = st_q.busy;
    assign done_o   = st_q.done;

    // R8: busy and done never overlap
    p_busy_not_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o) else $error("busy and done together");

    // R8: status reads 2 while an operation is pending
    p_busy_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> status_o == 4'h2) else $error("wrong status while busy");

    // R8: the accumulator only moves when a result is posted
    p_acc_moves_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(acc_o)) else $error("accumulator changed without done");

    // R9 R10 R11: error outcomes keep the accumulator
    p_fault_keeps_acc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (status_o == 4'hA || status_o == 4'hB || status_o == 4'hD)) |-> $stable(acc_o))
        else $error("accumulator changed on error");

    // R12: a start during a multi-cycle run does not end it early
    p_ignore_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && st_q.cnt > 2'd1) |=> (busy_o && !done_o))
        else $error("start accepted while busy");

endmodule

// File: tb/bytecode_alu_tb_top.sv
module bytecode_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = '0, opnd1_i = '0, opnd2_i = '0;
    logic [3:0]  err_i = '0;
    logic [7:0]  pc_i = '0;
    logic [3:0]  sp_i = '0;
    logic [15:0] ioa_i = '0;
    logic [7:0]  iob_i = '0;
    logic [15:0] acc_o;
    logic [3:0]  status_o;
    logic        busy_o, done_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_acc = '0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bytecode_alu dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .opcode_i(opcode_i), .opnd1_i(opnd1_i), .opnd2_i(opnd2_i),
        .err_i(err_i), .pc_i(pc_i), .sp_i(sp_i), .ioa_i(ioa_i), .iob_i(iob_i),
        .acc_o(acc_o), .status_o(status_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // operand model for R2 and R3
    function automatic bit m_val(input logic [7:0] c, output logic [15:0] v);
        v = '0;
        if (c <= 8'h9F) begin v = {8'h00, c}; return 1; end
        case (c)
            8'hD0: v = m_acc;
            8'hD1: v = {12'h0, err_i};
            8'hD2, 8'hD6: v = {8'h00, iob_i};
            8'hD3: v = {8'h00, pc_i};
            8'hD4: v = {12'h0, sp_i};
            8'hD5: v = ioa_i;
            8'hD7: v = {8'h00, ioa_i[15:8]};
            8'hD8: v = {8'h00, ioa_i[7:0]};
            default: return 0;
        endcase
        return 1;
    endfunction

    // full instruction model: returns cost, sets expected status and acc
    function automatic int m_exec(input logic [7:0] op, o1, o2,
                                  output int st, output logic [15:0] nacc);
        logic [15:0] x, y, r;
        bit ok1, ok2, fz;
        int sel, cost;
        nacc = m_acc;
        fz = 0;
        r = '0;
        if (op >= 8'hB0 && op <= 8'hB7 || op == 8'hBA || op == 8'hBB) begin
            ok1 = m_val(o1, x);
            ok2 = m_val(o2, y);
            if (op <= 8'hB7 && o2 == 8'h00) begin
                ok2 = 1; y = x; x = m_acc;
            end
            if (!(ok1 && ok2)) begin st = 'hB; return 1; end
            sel = (op == 8'hBA) ? 8 : (op == 8'hBB) ? 9 : int'(op[3:0]);
        end else if (op >= 8'hE0 && op <= 8'hE8) begin
            x = m_acc; y = {o1, o2};
            sel = (op == 8'hE8) ? 10 : int'(op[3:0]);
        end else begin
            st = 'hA; return 1;
        end
        case (sel)
            0: begin r = x + y; cost = 2; end
            1: begin r = x - y; cost = 2; end
            2: begin r = 16'((32'(x) * 32'(y)) & 32'hFFFF); cost = 3; end
            3: begin fz = (y == 0); if (!fz) r = x / y; cost = 3; end
            4: begin fz = (y == 0); if (!fz) r = x % y; cost = 2; end
            5: begin r = x & y; cost = 1; end
            6: begin r = x | y; cost = 1; end
            7: begin r = x ^ y; cost = 1; end
            8: begin r = (y >= 16) ? 16'h0 : 16'(x << y); cost = 1; end
            9: begin r = (y >= 16) ? 16'h0 : 16'(x >> y); cost = 1; end
            default: begin r = y; cost = 1; end
        endcase
        if (fz) st = 'hD;
        else begin st = 4; nacc = r; end
        return cost;
    endfunction

    task automatic run_op(input string req, input logic [7:0] op, o1, o2, input bit hold);
        int st, cost;
        logic [15:0] nacc;
        @(negedge clk);
        chk("R8", "done idle", int'(done_o), 0);
        opcode_i = op; opnd1_i = o1; opnd2_i = o2;
        cost = m_exec(op, o1, o2, st, nacc);
        start_i = 1'b1;
        for (int k = 1; k <= cost; k++) begin
            @(negedge clk);
            if (k < cost) begin
                chk(req, "busy", int'(busy_o), 1);
                chk(req, "busy status", int'(status_o), 2);
                chk(req, "done early", int'(done_o), 0);
            end else begin
                chk(req, "done", int'(done_o), 1);
                chk(req, "busy end", int'(busy_o), 0);
                chk(req, "status", int'(status_o), st);
                chk(req, "acc", int'(acc_o), int'(nacc));
            end
            if (hold && k == 1) begin
                opcode_i = 8'hE8; opnd1_i = 8'h12; opnd2_i = 8'h34;
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        m_acc = nacc;
    endtask

    function automatic logic [7:0] rnd_opnd(input bit allow_zero);
        int p = $urandom_range(0, 19);
        if (allow_zero && p < 4) return 8'h00;
        if (p < 11) return 8'($urandom_range(0, 8'h9F));
        if (p < 18) return 8'($urandom_range(8'hD0, 8'hD8));
        return (p == 18) ? 8'($urandom_range(8'hA0, 8'hCF)) : 8'($urandom_range(8'hD9, 8'hFE));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        err_i = 4'h7; pc_i = 8'h3C; sp_i = 4'h9; ioa_i = 16'hA1B2; iob_i = 8'h5E;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "acc", int'(acc_o), 0);
        chk("R1", "status", int'(status_o), 0);
        chk("R1", "busy", int'(busy_o), 0);
        chk("R1", "done", int'(done_o), 0);
        rst_n = 1'b1;

        run_op("R7", 8'hE8, 8'hAB, 8'hCD, 0);     // wide load
        run_op("R7", 8'hE0, 8'h01, 8'h00, 0);     // wide add
        run_op("R4", 8'hB0, 8'h05, 8'h00, 0);     // one-operand add
        run_op("R2", 8'hB1, 8'h05, 8'h07, 0);     // 5-7 wraps
        run_op("R3", 8'hB0, 8'hD7, 8'hD8, 0);     // I/O-A bytes
        run_op("R3", 8'hB6, 8'hD1, 8'hD4, 0);     // err | sp
        run_op("R3", 8'hB7, 8'hD3, 8'hD2, 0);     // pc ^ iob alias
        run_op("R3", 8'hB5, 8'hD5, 8'hD6, 0);     // ioa & iob
        run_op("R7", 8'hE8, 8'hFF, 8'hFF, 0);
        run_op("R7", 8'hE2, 8'hFF, 8'hFF, 0);     // wide multiply truncation
        run_op("R5", 8'hB3, 8'h9F, 8'h10, 0);     // floored 159/16
        run_op("R5", 8'hB4, 8'h9F, 8'h10, 0);
        run_op("R11", 8'hB3, 8'h10, 8'hD1, 0);    // err_i nonzero -> ok
        err_i = 4'h0;
        run_op("R11", 8'hB4, 8'h10, 8'hD1, 0);    // modulo by zero
        run_op("R11", 8'hE3, 8'h00, 8'h00, 0);    // wide divide by zero
        run_op("R6", 8'hBA, 8'h01, 8'h0F, 0);     // shift 15
        run_op("R6", 8'hBA, 8'h01, 8'h10, 0);     // shift 16 -> 0
        run_op("R6", 8'hBB, 8'hD5, 8'h04, 0);
        run_op("R6", 8'hBB, 8'hD5, 8'h00, 0);     // shift by literal 0
        run_op("R9", 8'hB0, 8'hA5, 8'h01, 0);     // reserved operand
        run_op("R9", 8'hB2, 8'h02, 8'hFF, 0);
        run_op("R10", 8'hB8, 8'h01, 8'h01, 0);    // unknown op
        run_op("R10", 8'hE9, 8'h01, 8'h01, 0);
        run_op("R12", 8'hB2, 8'h07, 8'h09, 1);    // start held during multiply

        for (int n = 0; n < 600; n++) begin
            logic [7:0] op;
            int pick = $urandom_range(0, 22);
            if (pick < 8) op = 8'hB0 + 8'(pick);
            else if (pick == 8) op = 8'hBA;
            else if (pick == 9) op = 8'hBB;
            else if (pick < 19) op = 8'hE0 + 8'(pick - 10);
            else op = 8'($urandom_range(0, 255));
            err_i = 4'($urandom); pc_i = 8'($urandom); sp_i = 4'($urandom);
            ioa_i = 16'($urandom); iob_i = 8'($urandom);
            if (op == 8'hBA || op == 8'hBB)
                run_op("R6", op, rnd_opnd(0), 8'($urandom_range(0, 20)), 0);
            else
                run_op("R5", op, rnd_opnd(0), rnd_opnd(1), ($urandom_range(0, 9) == 0));
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule